// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block lets a pipeline run loads that were moved above earlier stores, and then confirm afterwards that the move was safe. When a speculative load executes, it records its destination register tag, its word address, and one flag in a small table. The flag says whether instructions that depend on the load were also moved early. Each store that executes later compares its address with every occupied entry. A match marks that entry as failed.

At the position where the load stood in program order, a check operation looks up the same register tag. One cycle later the block answers with success or failure. On failure it also says which recovery is needed: reissue only the load, or re-execute the whole dependent sequence that was speculated. Each check frees its entry. When the table is full and a new tag arrives, a round-robin pointer picks the entry to replace.

Top module: `spec_load_table`

## Requirements
- R1: A load with `ld_valid` high records its tag, the address bits above bit 1, and `ld_chain`. It uses the lowest-index free entry when its tag is not already held.
- R2: A check of a tag whose entry has seen no matching store returns `resp_ok`=1 and `resp_replay_all`=0 in the cycle after the check.
- R3: A store whose `st_addr` bits above bit 1 equal an entry's recorded address marks that entry failed. A later check of that tag returns `resp_ok`=0, with `resp_replay_all` equal to the recorded chain flag (1 = re-execute the dependent sequence, 0 = reissue the load only).
- R4: Address bits [1:0] play no part in matching. A store that differs only in those bits conflicts, and a store that differs in bit 2 or above has no effect.
- R5: A check whose tag is in no entry returns `resp_ok`=0 and `resp_replay_all`=1.
- R6: Every check frees the entry it found, so a repeated check of the same tag with no new load fails as in R5.
- R7: A load to a tag already held overwrites that entry's address and chain flag and clears its failed mark.
- R8: When all entries are occupied and a load brings a new tag, the entry named by a pointer is replaced. The pointer is 0 after reset and advances by one, wrapping, per such replacement. The displaced tag then fails as in R5.
- R9: When a store and a check fall in the same cycle, the store takes effect first and can fail that check.
- R10: A store in the same cycle as a load does not mark the entry that load writes. A check in the same cycle as a load of the same tag sees the old entry, and the load's entry is then installed.
- R11: `resp_valid` is high exactly in the cycle after each check. While it is low, `resp_ok` and `resp_replay_all` are 0, and all three are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Speculative load executes this cycle |
| ld_tag | input | TAGW | Destination register tag of the load |
| ld_addr | input | AW | Byte address of the load |
| ld_chain | input | 1 | Dependent instructions were also speculated |
| st_valid | input | 1 | Store executes this cycle |
| st_addr | input | AW | Byte address of the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_tag | input | TAGW | Register tag being checked |
| resp_valid | output | 1 | Check result valid |
| resp_ok | output | 1 | Reordering was safe |
| resp_replay_all | output | 1 | On failure: 1 = re-execute dependent sequence, 0 = reissue load only |

## Verification
A store snoop and a check can land on the same entry in the same cycle. Two other pairings also share a cycle: a load with a store, and a load with a check of its own tag. The bench drives each pairing in a single cycle and compares the response against the stated ordering, store before check and old entry before new load. A full sweep loads every entry, kills each one in turn with a store carrying a byte offset, and checks all eight tags. The expected success and recovery flags follow arithmetically from the tag index.

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES = 8,
  parameter int TAGW    = 5,
  parameter int AW      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  input  logic [TAGW-1:0] ld_tag,
  input  logic [AW-1:0]   ld_addr,
  input  logic            ld_chain,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic            chk_valid,
  input  logic [TAGW-1:0] chk_tag,
  output logic            resp_valid,
  output logic            resp_ok,
  output logic            resp_replay_all
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int WW = AW - 2;

  logic [ENTRIES-1:0] used, dead, chain;
  logic [TAGW-1:0]    tag_q  [ENTRIES];
  logic [WW-1:0]      word_q [ENTRIES];
  logic [IW-1:0]      rr;

  logic [ENTRIES-1:0] ld_hit, st_hit, ck_hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign ld_hit[i] = used[i] && tag_q[i] == ld_tag;
    assign ck_hit[i] = used[i] && tag_q[i] == chk_tag;
    assign st_hit[i] = used[i] && st_valid && word_q[i] == st_addr[AW-1:2];
  end

  logic [IW-1:0] slot;
  logic          found;
  always_comb begin
    slot  = rr;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && ld_hit[i]) begin slot = IW'(i); found = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !used[i]) begin slot = IW'(i); found = 1'b1; end
  end

  wire evict    = ld_valid && !found;
  wire ck_live  = |(ck_hit & ~(dead | st_hit));
  wire ck_any   = |ck_hit;
  wire ck_chain = |(ck_hit & chain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      dead <= '0;
      chain <= '0;
      rr <= '0;
      resp_valid <= 1'b0;
      resp_ok <= 1'b0;
      resp_replay_all <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ld_valid && slot == IW'(i)) begin
          used[i]  <= 1'b1;
          dead[i]  <= 1'b0;
          chain[i] <= ld_chain;
        end else if (chk_valid && ck_hit[i]) begin
          used[i] <= 1'b0;
        end else if (st_hit[i]) begin
          dead[i] <= 1'b1;
        end
      end
      if (evict) rr <= (rr == IW'(ENTRIES-1)) ? '0 : rr + 1'b1;
      resp_valid      <= chk_valid;
      resp_ok         <= chk_valid && ck_live;
      resp_replay_all <= chk_valid && !ck_live && (!ck_any || ck_chain);
    end
  end

  always_ff @(posedge clk)
    for (int i = 0; i < ENTRIES; i++)
      if (ld_valid && slot == IW'(i)) begin
        tag_q[i]  <= ld_tag;
        word_q[i] <= ld_addr[AW-1:2];
      end
endmodule

// File: rtl/spec_load_table_chk.sv
module spec_load_table_chk #(
  parameter int TAGW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_valid,
  input logic            chk_valid,
  input logic [TAGW-1:0] chk_tag,
  input logic            resp_valid,
  input logic            resp_ok,
  input logic            resp_replay_all
);
  // R11
  resp_follows_chk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> resp_valid);
  // R11
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !resp_valid && !resp_ok && !resp_replay_all);
  // R3
  ok_excludes_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ok |-> !resp_replay_all);
  // R6
  repeat_check_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid ##1 (chk_valid && chk_tag == $past(chk_tag) && !$past(ld_valid)))
      |=> resp_valid && !resp_ok && resp_replay_all);
endmodule

bind spec_load_table spec_load_table_chk #(.TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .chk_valid(chk_valid),
  .chk_tag(chk_tag), .resp_valid(resp_valid), .resp_ok(resp_ok),
  .resp_replay_all(resp_replay_all)
);

// File: tb/tb_spec_load_table.sv
`timescale 1ns/1ps
module tb_spec_load_table;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 0, ld_chain = 0, st_valid = 0, chk_valid = 0;
  logic [4:0] ld_tag = '0, chk_tag = '0;
  logic [31:0] ld_addr = '0, st_addr = '0;
  logic resp_valid, resp_ok, resp_replay_all;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spec_load_table dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_tag(ld_tag),
    .ld_addr(ld_addr), .ld_chain(ld_chain), .st_valid(st_valid),
    .st_addr(st_addr), .chk_valid(chk_valid), .chk_tag(chk_tag),
    .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_replay_all(resp_replay_all)
  );

  task automatic cmp(input logic v, input logic ok, input logic all, input string req);
    compared++;
    if (resp_valid !== v || resp_ok !== ok || resp_replay_all !== all) begin
      mismatched++;
      $display("FAIL %s: got v=%0b ok=%0b all=%0b, expected v=%0b ok=%0b all=%0b",
               req, resp_valid, resp_ok, resp_replay_all, v, ok, all);
    end
  endtask

  task automatic step(input logic lv, input logic [4:0] lt, input logic [31:0] la,
                      input logic lc, input logic sv, input logic [31:0] sa,
                      input logic cv, input logic [4:0] ct,
                      input logic eok, input logic eall, input string req);
    ld_valid = lv; ld_tag = lt; ld_addr = la; ld_chain = lc;
    st_valid = sv; st_addr = sa; chk_valid = cv; chk_tag = ct;
    @(negedge clk);
    ld_valid = 0; st_valid = 0; chk_valid = 0;
    if (cv) cmp(1'b1, eok, eall, req);
  endtask

  task automatic ld(input logic [4:0] t, input logic [31:0] a, input logic c);
    step(1, t, a, c, 0, '0, 0, '0, 0, 0, "");
  endtask
  task automatic st(input logic [31:0] a);
    step(0, '0, '0, 0, 1, a, 0, '0, 0, 0, "");
  endtask
  task automatic ck(input logic [4:0] t, input logic eok, input logic eall, input string req);
    step(0, '0, '0, 0, 0, '0, 1, t, eok, eall, req);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp(1'b0, 1'b0, 1'b0, "R11 reset");
    ck(5'd0, 0, 1, "R5 empty table after reset");
    @(negedge clk);
    cmp(1'b0, 1'b0, 1'b0, "R11 idle");

    // R1 R2 R3 R4: fill, kill entry k with a byte-offset store, check all
    for (int k = 0; k < 8; k++) begin
      for (int t = 0; t < 8; t++) ld(5'(t), 32'h100 + 32'(16 * t), t[0]);
      st(32'h100 + 32'(16 * k) + 32'(k % 4));
      for (int t = 0; t < 8; t++)
        if (t == k) ck(5'(t), 0, t[0], "R3 conflicting store");
        else        ck(5'(t), 1, 0, "R2 no conflict");
    end

    // R4
    ld(5'd3, 32'h200, 0); st(32'h204); ck(5'd3, 1, 0, "R4 bit2 differs");
    ld(5'd3, 32'h200, 1); st(32'h203); ck(5'd3, 0, 1, "R4 byte offset ignored");

    // R6
    ld(5'd2, 32'h240, 0); ck(5'd2, 1, 0, "R6 first check");
    ck(5'd2, 0, 1, "R6 entry freed");

    // R7
    ld(5'd5, 32'h800, 1); ld(5'd5, 32'h900, 0); st(32'h800);
    ck(5'd5, 1, 0, "R7 address overwritten");
    ld(5'd5, 32'hA00, 1); st(32'hA00); ld(5'd5, 32'hA00, 0);
    ck(5'd5, 1, 0, "R7 failed mark cleared");

    // R8
    for (int t = 8; t < 16; t++) ld(5'(t), 32'h1000 + 32'(16 * t), 0);
    ld(5'd16, 32'h2000, 0);
    ck(5'd8, 0, 1, "R8 first victim entry 0");
    ld(5'd17, 32'h2010, 0);
    ck(5'd9, 0, 1, "R8 second victim entry 1");
    for (int t = 10; t < 18; t++) ck(5'(t), 1, 0, "R8 survivors");

    // R9
    ld(5'd4, 32'h300, 0);
    step(0, '0, '0, 0, 1, 32'h300, 1, 5'd4, 0, 0, "R9 store before check");
    ld(5'd4, 32'h300, 1);
    step(0, '0, '0, 0, 1, 32'h500, 1, 5'd4, 1, 0, "R9 unrelated store");

    // R10
    step(1, 5'd6, 32'h400, 0, 1, 32'h400, 0, '0, 0, 0, "");
    ck(5'd6, 1, 0, "R10 store with load");
    ld(5'd7, 32'h600, 0);
    step(1, 5'd7, 32'h700, 1, 0, '0, 1, 5'd7, 1, 0, "R10 check sees old entry");
    st(32'h700);
    ck(5'd7, 0, 1, "R10 new entry installed");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule